// File: doc/BRIEF.md
# ATA PIO Register Transfer Sequencer

This block is the host-side timing engine for one register read or one register write on a parallel ATA bus. A request carries the direction, a register address, the byte to write and a PIO mode from 0 to 4. The engine then moves through four phases. It puts the address out first. It then asserts the read or write strobe and holds it, waiting on the device's ready line when asked. After it negates the strobe, it holds the address and the write drive before it frees itself for the next request.

All timing is counted in clock cycles of a 10 ns clock, set by the `CLK_NS` parameter. Every nanosecond limit is rounded up to whole cycles. The limits come from a table built at elaboration. Each mode has a minimum period, an address setup, a minimum strobe width, a minimum strobe recovery and an address hold. When the setup, width and recovery together fall short of the mode's period, the strobe width is stretched until they reach it.

The device can slow a transfer by pulling the ready line low. The engine first looks at that line 4 cycles after the strobe asserts. After that it keeps the strobe asserted until the line is high. If the line stays low past a 1250 ns limit, the engine gives up and reports a timeout together with the done pulse.

Top module: `pio_reg_seq`

## Requirements
- R1: After reset the read and write strobes are high, the data drive enable, done and timeout are low, and `req_ready` is high.
- R2: A request is accepted at a clock edge where `req_valid` and `req_ready` are both high. The strobe asserts exactly `S` edges later, where `S` is 7, 5, 3, 3 and 3 cycles for modes 0 to 4.
- R3: When the ready line causes no wait, the strobe stays asserted for `W` cycles. `W` is the larger of the mode's minimum width (29, 29, 29, 8, 7) and the period (60, 39, 33, 18, 12) minus `S` minus `H`. With no wait, `S + W + H` is never less than the period.
- R4: From strobe negation to the done pulse there are `H` cycles. `H` is the larger of the recovery minimum (0, 0, 0, 7, 3) and the address hold (2, 2, 1, 1, 1). `req_ready` rises on the same edge as done.
- R5: A read asserts only `ata_rd_n` and a write asserts only `ata_wr_n`. The two are never low together.
- R6: The ready line first counts on the 4th edge after strobe assertion. If it is low there, the strobe stays asserted until the first edge at or after that point where the line is high. It is also held for at least `W` cycles. A low level that ends before the 4th edge has no effect.
- R7: If the ready line is still low on the 129th edge after strobe assertion (4 plus 125), the strobe negates on that edge. `rsp_timeout` is high during the done cycle, and low with every other done.
- R8: For a read, `rsp_rdata` holds the value that `ata_rdata_in` had on the last clock edge before the strobe negates. It is valid from the done cycle on.
- R9: For a write, `ata_data_oe` is high from acceptance until the address-hold count (2, 2, 1, 1, 1 cycles) after strobe negation. `ata_wdata` equals the request byte throughout. For a read, `ata_data_oe` stays low.
- R10: `ata_addr` holds the accepted address from acceptance until done.
- R11: A request raised while the engine is busy is ignored. It changes neither the address nor the timing, and each accepted request gives exactly one done pulse.
- R12: Mode codes 5, 6 and 7 use the mode 0 timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one cycle per `CLK_NS` ns |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is high |
| req_write | input | 1 | 1 for a register write, 0 for a read |
| req_addr | input | ADDR_W | Register address |
| req_wdata | input | DATA_W | Byte to write |
| req_mode | input | 3 | PIO mode, 0 to 4 (5 to 7 act as 0) |
| req_ready | output | 1 | Engine idle, a request may be taken |
| ata_addr | output | ADDR_W | Address lines to the device |
| ata_rd_n | output | 1 | Read strobe, active low |
| ata_wr_n | output | 1 | Write strobe, active low |
| ata_data_oe | output | 1 | Host drives the data lines |
| ata_wdata | output | DATA_W | Data driven to the device |
| ata_rdata_in | input | DATA_W | Data lines from the device |
| ata_iordy | input | 1 | Device ready line, low means wait |
| rsp_done | output | 1 | One-cycle pulse at the end of a transfer |
| rsp_rdata | output | DATA_W | Captured read byte |
| rsp_timeout | output | 1 | Ready wait expired, valid with done |

## Verification
Counted from the acceptance edge, the strobe falls `S` edges later and rises `S+W` edges later, the write drive drops `S+W+hold` edges later, and done comes `S+W+H` edges later. The bench samples every output on the falling clock edge, one sample per cycle. From those samples it takes the index of the first strobe-low sample, the count of low samples, the index of the last one and the index of the done sample, and compares them with arithmetic on its own nanosecond tables. The device data changes on every falling edge, so a capture one edge early or late shows up as a different byte. The ready line is released at chosen offsets from the first strobe-low sample: before, at and after the 4th edge, and on each side of the 129-edge limit.

// File: rtl/pio_pkg.sv
package pio_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_STROBE = 2'd2,
        ST_POST   = 2'd3
    } pio_state_e;

    localparam int unsigned NUM_MODES  = 5;
    localparam int unsigned READY_NS   = 35;

    function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // minimum period, address valid to next address valid
    function automatic int unsigned period_ns(input int unsigned m);
        case (m)
            1:       return 383;
            2:       return 330;
            3:       return 180;
            4:       return 120;
            default: return 600;
        endcase
    endfunction

    function automatic int unsigned setup_ns(input int unsigned m);
        case (m)
            1:       return 50;
            4:       return 25;
            2, 3:    return 30;
            default: return 70;
        endcase
    endfunction

    function automatic int unsigned width_ns(input int unsigned m);
        case (m)
            3:       return 80;
            4:       return 70;
            default: return 290;
        endcase
    endfunction

    function automatic int unsigned recov_ns(input int unsigned m);
        case (m)
            3:       return 70;
            4:       return 25;
            default: return 0;
        endcase
    endfunction

    function automatic int unsigned hold_ns(input int unsigned m);
        case (m)
            0:       return 20;
            1:       return 15;
            default: return 10;
        endcase
    endfunction

endpackage

// File: rtl/pio_timing_rom.sv
module pio_timing_rom
    import pio_pkg::*;
#(
    parameter int unsigned CLK_NS = 10,
    parameter int unsigned CNT_W  = 8
) (
    input  logic [2:0]       mode,
    output logic [CNT_W-1:0] setup_c,
    output logic [CNT_W-1:0] active_c,
    output logic [CNT_W-1:0] post_c,
    output logic [CNT_W-1:0] hold_c
);

    logic [CNT_W-1:0] setup_tab  [NUM_MODES];
    logic [CNT_W-1:0] active_tab [NUM_MODES];
    logic [CNT_W-1:0] post_tab   [NUM_MODES];
    logic [CNT_W-1:0] hold_tab   [NUM_MODES];

    for (genvar g = 0; g < NUM_MODES; g++) begin : g_mode
        localparam int unsigned T0   = ns2cyc(period_ns(g), CLK_NS);
        localparam int unsigned T1   = ns2cyc(setup_ns(g), CLK_NS);
        localparam int unsigned T2   = ns2cyc(width_ns(g), CLK_NS);
        localparam int unsigned T2I  = ns2cyc(recov_ns(g), CLK_NS);
        localparam int unsigned T9   = ns2cyc(hold_ns(g), CLK_NS);
        localparam int unsigned POST = umax(umax(T2I, T9), 1);
        localparam int unsigned FILL = (T0 > T1 + POST) ? (T0 - T1 - POST) : 0;
        localparam int unsigned ACT  = umax(T2, FILL);
        assign setup_tab[g]  = CNT_W'(umax(T1, 1));
        assign active_tab[g] = CNT_W'(umax(ACT, 1));
        assign post_tab[g]   = CNT_W'(POST);
        assign hold_tab[g]   = CNT_W'(umax(T9, 1));
    end

    always_comb begin
        setup_c  = setup_tab[0];
        active_c = active_tab[0];
        post_c   = post_tab[0];
        hold_c   = hold_tab[0];
        for (int i = 1; i < NUM_MODES; i++) begin
            if (mode == 3'(i)) begin
                setup_c  = setup_tab[i];
                active_c = active_tab[i];
                post_c   = post_tab[i];
                hold_c   = hold_tab[i];
            end
        end
    end

endmodule

// File: rtl/pio_wait_ctrl.sv
module pio_wait_ctrl #(
    parameter int unsigned CNT_W = 8,
    parameter int unsigned TA_C  = 4,
    parameter int unsigned TMO_C = 125
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_strobe,
    input  logic [CNT_W-1:0] elapsed,
    input  logic             iordy,
    output logic             ready_ok,
    output logic             expired
);

    localparam logic [CNT_W-1:0] TA_K  = CNT_W'(TA_C);
    localparam logic [CNT_W-1:0] LIM_K = CNT_W'(TA_C + TMO_C);

    logic ok_d, ok_q;

    always_comb begin
        ready_ok = ok_q | ((elapsed >= TA_K) & iordy);
        expired  = in_strobe & ~ready_ok & (elapsed >= LIM_K);
        ok_d     = in_strobe & ready_ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ok_q <= 1'b0;
        else        ok_q <= ok_d;
    end

endmodule

// File: rtl/pio_reg_seq.sv
module pio_reg_seq
    import pio_pkg::*;
#(
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CLK_NS = 10,
    parameter int unsigned TMO_NS = 1250
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [2:0]        req_mode,
    output logic              req_ready,
    output logic [ADDR_W-1:0] ata_addr,
    output logic              ata_rd_n,
    output logic              ata_wr_n,
    output logic              ata_data_oe,
    output logic [DATA_W-1:0] ata_wdata,
    input  logic [DATA_W-1:0] ata_rdata_in,
    input  logic              ata_iordy,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_timeout
);

    localparam int unsigned TA_C  = ns2cyc(READY_NS, CLK_NS);
    localparam int unsigned TMO_C = ns2cyc(TMO_NS, CLK_NS);
    localparam int unsigned CNT_W = $clog2(TA_C + TMO_C + ns2cyc(period_ns(0), CLK_NS) + 2);

    typedef struct packed {
        pio_state_e        st;
        logic              wr;
        logic [2:0]        mode;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              oe;
        logic [CNT_W-1:0]  cnt;
        logic              tmo;
        logic              done;
        logic              tmo_out;
        logic [DATA_W-1:0] rdata;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [CNT_W-1:0] setup_c, active_c, post_c, hold_c;
    logic [CNT_W-1:0] elapsed;
    logic             in_strobe, ready_ok, expired;

    assign elapsed   = seq_q.cnt + CNT_W'(1);
    assign in_strobe = (seq_q.st == ST_STROBE);

    pio_timing_rom #(
        .CLK_NS (CLK_NS),
        .CNT_W  (CNT_W)
    ) i_rom (
        .mode     (seq_q.mode),
        .setup_c  (setup_c),
        .active_c (active_c),
        .post_c   (post_c),
        .hold_c   (hold_c)
    );

    pio_wait_ctrl #(
        .CNT_W (CNT_W),
        .TA_C  (TA_C),
        .TMO_C (TMO_C)
    ) i_wait (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_strobe (in_strobe),
        .elapsed   (elapsed),
        .iordy     (ata_iordy),
        .ready_ok  (ready_ok),
        .expired   (expired)
    );

    always_comb begin
        seq_d         = seq_q;
        seq_d.done    = 1'b0;
        seq_d.tmo_out = 1'b0;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    seq_d.st    = ST_SETUP;
                    seq_d.wr    = req_write;
                    seq_d.mode  = req_mode;
                    seq_d.addr  = req_addr;
                    seq_d.wdata = req_wdata;
                    seq_d.oe    = req_write;
                    seq_d.cnt   = '0;
                    seq_d.tmo   = 1'b0;
                end
            end
            ST_SETUP: begin
                seq_d.cnt = elapsed;
                if (elapsed >= setup_c) begin
                    seq_d.st  = ST_STROBE;
                    seq_d.cnt = '0;
                end
            end
            ST_STROBE: begin
                seq_d.cnt = elapsed;
                if (((elapsed >= active_c) && ready_ok) || expired) begin
                    seq_d.st  = ST_POST;
                    seq_d.cnt = '0;
                    seq_d.tmo = expired;
                    if (!seq_q.wr) seq_d.rdata = ata_rdata_in;
                end
            end
            ST_POST: begin
                seq_d.cnt = elapsed;
                if (elapsed >= hold_c) seq_d.oe = 1'b0;
                if (elapsed >= post_c) begin
                    seq_d.st      = ST_IDLE;
                    seq_d.oe      = 1'b0;
                    seq_d.done    = 1'b1;
                    seq_d.tmo_out = seq_q.tmo;
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign req_ready   = (seq_q.st == ST_IDLE);
    assign ata_addr    = seq_q.addr;
    assign ata_rd_n    = ~(in_strobe & ~seq_q.wr);
    assign ata_wr_n    = ~(in_strobe & seq_q.wr);
    assign ata_data_oe = seq_q.oe;
    assign ata_wdata   = seq_q.wdata;
    assign rsp_done    = seq_q.done;
    assign rsp_rdata   = seq_q.rdata;
    assign rsp_timeout = seq_q.tmo_out;

endmodule

// File: rtl/pio_reg_seq_chk.sv
module pio_reg_seq_chk #(
    parameter int unsigned ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic [ADDR_W-1:0] ata_addr,
    input logic              ata_rd_n,
    input logic              ata_wr_n,
    input logic              ata_data_oe,
    input logic              rsp_done,
    input logic              rsp_timeout
);

    // R5
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ata_rd_n && !ata_wr_n));

    // R10
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && $past(!req_ready)) |-> $stable(ata_addr));

    // R7
    tmo_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_timeout |-> rsp_done);

    // R9
    wr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ata_wr_n |-> ata_data_oe);

    // R11
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> req_ready);

    // R2
    strobe_after_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ata_rd_n) || $fell(ata_wr_n)) |-> (!req_ready && $past(!req_ready)));

    // R3
    rd_min_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ata_rd_n) |-> ($past(!ata_rd_n, 2) && $past(!ata_rd_n, 3)));

endmodule

bind pio_reg_seq pio_reg_seq_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ready   (req_ready),
    .ata_addr    (ata_addr),
    .ata_rd_n    (ata_rd_n),
    .ata_wr_n    (ata_wr_n),
    .ata_data_oe (ata_data_oe),
    .rsp_done    (rsp_done),
    .rsp_timeout (rsp_timeout)
);

// File: tb/test_pio_reg_seq.sv
module test_pio_reg_seq;

    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;
    localparam int TA     = 4;
    localparam int TMO    = 125;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic [2:0]        req_mode = '0;
    logic              req_ready;
    logic [ADDR_W-1:0] ata_addr;
    logic              ata_rd_n, ata_wr_n, ata_data_oe;
    logic [DATA_W-1:0] ata_wdata;
    logic [DATA_W-1:0] ata_rdata_in = '0;
    logic              ata_iordy = 1'b1;
    logic              rsp_done;
    logic [DATA_W-1:0] rsp_rdata;
    logic              rsp_timeout;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    pio_reg_seq i_pio_reg_seq (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_write (req_write), .req_addr (req_addr),
        .req_wdata (req_wdata), .req_mode (req_mode), .req_ready (req_ready),
        .ata_addr (ata_addr), .ata_rd_n (ata_rd_n), .ata_wr_n (ata_wr_n),
        .ata_data_oe (ata_data_oe), .ata_wdata (ata_wdata),
        .ata_rdata_in (ata_rdata_in), .ata_iordy (ata_iordy),
        .rsp_done (rsp_done), .rsp_rdata (rsp_rdata), .rsp_timeout (rsp_timeout)
    );

    function automatic int cdiv(input int ns);
        return (ns + 9) / 10;
    endfunction
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
    function automatic int eff(input int m);
        return (m > 4) ? 0 : m;
    endfunction
    function automatic int e_setup(input int m);
        int t[5] = '{70, 50, 30, 30, 25};
        return cdiv(t[eff(m)]);
    endfunction
    function automatic int e_hold(input int m);
        int t[5] = '{20, 15, 10, 10, 10};
        return cdiv(t[eff(m)]);
    endfunction
    function automatic int e_post(input int m);
        int t[5] = '{0, 0, 0, 70, 25};
        return imax(cdiv(t[eff(m)]), e_hold(m));
    endfunction
    function automatic int e_period(input int m);
        int t[5] = '{600, 383, 330, 180, 120};
        return cdiv(t[eff(m)]);
    endfunction
    function automatic int e_width(input int m);
        int t[5] = '{290, 290, 290, 80, 70};
        return imax(cdiv(t[eff(m)]), e_period(m) - e_setup(m) - e_post(m));
    endfunction
    function automatic logic [7:0] devbyte(input int j, input int seed);
        return 8'((j * 37 + seed) & 255);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // rel < 0: ready line stays high; otherwise low until rel samples after strobe first seen low
    task automatic xfer(input bit wr, input int mode, input int rel, input int addr, input int seed);
        int jf = 0, jl = 0, jd = 0, wcnt = 0, oecnt = 0;
        int bad_addr = 0, bad_data = 0, bad_dir = 0, dones = 0;
        int ok_k, exp_w, exp_tmo, got_rd = 0, got_tmo = 0;
        logic [7:0] exp_rd = '0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_write = wr; req_mode = 3'(mode); req_addr = ADDR_W'(addr);
        req_wdata = 8'(seed ^ 8'h5A); req_valid = 1'b1;
        if (rel >= 0) ata_iordy = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        for (int j = 1; j < 400; j++) begin
            if (j > 1) @(negedge clk);
            if (ata_addr != ADDR_W'(addr)) bad_addr++;
            if ((wr && !ata_rd_n) || (!wr && !ata_wr_n)) bad_dir++;
            if (ata_data_oe) begin
                oecnt++;
                if (ata_wdata != 8'(seed ^ 8'h5A)) bad_data++;
            end
            if ((wr ? ata_wr_n : ata_rd_n) == 1'b0) begin
                if (jf == 0) jf = j;
                wcnt++; jl = j;
            end
            if (rsp_done) begin
                dones++; jd = j; got_rd = rsp_rdata; got_tmo = rsp_timeout;
                break;
            end
            ata_rdata_in = devbyte(j, seed);
            if (j == 3) begin
                req_valid = 1'b1; req_addr = ADDR_W'(addr + 1);
            end
            if (j == 4) req_valid = 1'b0;
            if (rel >= 0 && jf != 0 && j == jf + rel) ata_iordy = 1'b1;
        end
        ata_iordy = 1'b1;
        exp_rd = devbyte(jl, seed);
        ok_k = (rel < 0) ? 0 : rel + 1;
        if (ok_k > TA + TMO) begin
            exp_w = TA + TMO; exp_tmo = 1;
        end else begin
            exp_w = imax(e_width(mode), ok_k); exp_tmo = 0;
        end
        chk("R2 setup cycles", jf - 1, e_setup(mode));
        chk((rel < 0) ? "R3 strobe width" : ((exp_tmo != 0) ? "R7 width at expiry" : "R6 waited width"),
            wcnt, exp_w);
        chk("R4 post-strobe cycles", jd - jl - 1, e_post(mode));
        chk("R7 timeout flag", got_tmo, exp_tmo);
        chk("R5 wrong-direction strobe", bad_dir, 0);
        chk("R10 address changes", bad_addr, 0);
        chk("R11 done pulses", dones, 1);
        if (rel < 0) chk("R3 total vs period", (jf - 1 + wcnt + e_post(mode) >= e_period(mode)) ? 1 : 0, 1);
        if (wr) begin
            chk("R9 drive cycles", oecnt, e_setup(mode) + exp_w + e_hold(mode));
            chk("R9 write data", bad_data, 0);
        end else begin
            chk("R9 read drive cycles", oecnt, 0);
            chk("R8 read capture", got_rd, int'(exp_rd));
        end
        if (mode > 4) chk("R12 high mode as mode 0", wcnt, e_width(0));
        @(negedge clk);
        chk("R11 done single cycle", rsp_done, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 rd strobe", ata_rd_n, 1);
        chk("R1 wr strobe", ata_wr_n, 1);
        chk("R1 data drive", ata_data_oe, 0);
        chk("R1 done", rsp_done, 0);
        chk("R1 timeout", rsp_timeout, 0);
        chk("R1 ready", req_ready, 1);
        rst_n = 1'b1;
        for (int m = 0; m < 8; m++) begin
            xfer(1'b0, m, -1, m, 11 + m);
            xfer(1'b1, m, -1, 7 - m, 90 + m);
        end
        xfer(1'b0, 4, 2, 1, 3);
        xfer(1'b0, 4, 3, 2, 4);
        xfer(1'b1, 4, 10, 3, 5);
        xfer(1'b0, 3, 5, 4, 6);
        xfer(1'b0, 0, 40, 5, 7);
        xfer(1'b0, 4, 127, 6, 8);
        xfer(1'b1, 2, 128, 0, 9);
        xfer(1'b0, 4, 129, 1, 10);
        xfer(1'b1, 1, 150, 2, 12);
        xfer(1'b0, 4, -1, 3, 13);
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule